// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block connects an on-chip request stream to an external asynchronous static RAM. The RAM has a 20-bit word address, a 36-bit shared data bus split into four 9-bit lanes, one active-low enable per lane, an active-low write strobe and an active-low output enable. Each request is a read or a write to one word and carries a 4-bit lane mask. Only the lanes named in the mask take part in the access. A read returns the enabled lanes and zeros in the others.

The memory's timing figures (cycle time, access time, pulse width, data setup, address setup, hold and output release) are parameters in nanoseconds, and the clock period is a parameter as well. Each phase of an access is the minimum time divided by the period and rounded up, with a floor of one cycle. The data bus is modelled as three signals: a drive value, a drive enable and a sampled input. The pad cell outside this block combines them.

Requests use a valid/ready handshake. `req_ready` is high only while the controller is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. While an access is in progress `req_ready` stays low. The requester must then hold the request stable, and requests are served strictly one at a time, in order. Read data comes back as a one-cycle `rsp_valid` pulse. The response side has no back-pressure, so the consumer must accept it in that cycle.

Top module: `sram_lane_ctrl`

## Requirements
- R1: During reset and on the first cycle after it: `req_ready` is 1, `mem_ce_n` is 4'hF, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0 and `rsp_valid` is 0.
- R2: A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. From the next cycle, `req_ready` stays low until the access and its recovery phase have ended. Read responses come back in request order.
- R3: Lane k covers data bits 9k to 9k+8. During an access, `mem_ce_n[k]` is low exactly when mask bit k of the request is 1. Outside an access all four enables are high.
- R4: A read holds `mem_oe_n` low with `mem_we_n` high for RD_CYC consecutive cycles. RD_CYC is the larger of the rounded-up access time and the rounded-up read cycle time, which is 2 cycles with the defaults.
- R5: Read data is sampled in the last cycle of the read phase. It appears on `rsp_rdata` with `rsp_valid` high for exactly one cycle, the cycle right after. Lanes whose mask bit is 0 read as zero.
- R6: A write first spends AS_CYC cycles (at least 1) with the lanes enabled and `mem_we_n` high. It then holds `mem_we_n` low for WP_CYC cycles, where WP_CYC is the largest of the rounded-up pulse width, address-to-end and data-setup times (2 with the defaults). At least one hold cycle follows, with the data still driven after `mem_we_n` rises.
- R7: A write changes only the lanes whose mask bit is 1. The other lanes of the word keep their earlier contents.
- R8: `mem_dq_oe` is high only during the strobe and hold phases of a write, and never while `mem_oe_n` is low.
- R9: After a read, at least HZ_CYC cycles pass with `mem_oe_n` high before `mem_dq_oe` can rise. HZ_CYC is the rounded-up output release time, at least 1.
- R10: `mem_addr` and `mem_ce_n` stay constant for as long as any lane enable is held low during an access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_lanes | input | 4 | Lane mask, bit k selects data bits 9k..9k+8 |
| req_wdata | input | 36 | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 36 | Read data, disabled lanes zero |
| mem_addr | output | 20 | Memory address |
| mem_ce_n | output | 4 | Active-low lane enables |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 36 | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | 36 | Value sampled from the data bus |

## Verification
The assertions check the following on every cycle:
- the bus is never driven while the memory's outputs are enabled;
- the write strobe is never low together with the output enable;
- the address and lane enables stay stable through an access;
- the response pulse lasts one cycle;
- ready drops after an acceptance;
- the write pulse length and the read-to-write release gap are at least their minimum cycle counts.

Other behaviour can only be shown by the bench's scenarios with its memory model. This covers partial-lane writes that leave the other lanes of a word unchanged, zero fill of disabled lanes on reads, exact phase lengths, in-order responses, and the mapping from mask bits to enables at the highest address.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RD_ACC,
    PH_RD_TURN,
    PH_WR_SETUP,
    PH_WR_PULSE,
    PH_WR_HOLD
  } phase_e;

  // rounded-up cycle count for a minimum time, never below one cycle
  function automatic int ns_to_cycles(input int t_ns, input int clk_ns);
    int c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_map.sv
module sram_lane_map #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int DATA_W = LANES * LANE_W
) (
  input  logic              active,
  input  logic [LANES-1:0]  mask,
  input  logic [DATA_W-1:0] dq_in,
  output logic [LANES-1:0]  ce_n,
  output logic [DATA_W-1:0] rd_masked
);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign ce_n[k] = ~(active & mask[k]);
    assign rd_masked[k*LANE_W +: LANE_W] = mask[k] ? dq_in[k*LANE_W +: LANE_W] : '0;
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int LANES   = 4,
  parameter int LANE_W  = 9,
  parameter int CLK_NS  = 10,
  parameter int T_RC_NS = 15,
  parameter int T_AA_NS = 15,
  parameter int T_WC_NS = 15,
  parameter int T_WP_NS = 12,
  parameter int T_AW_NS = 12,
  parameter int T_DW_NS = 10,
  parameter int T_AS_NS = 0,
  parameter int T_DH_NS = 0,
  parameter int T_HZ_NS = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [LANES-1:0]          req_lanes,
  input  logic [LANES*LANE_W-1:0]   req_wdata,
  output logic                      rsp_valid,
  output logic [LANES*LANE_W-1:0]   rsp_rdata,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [LANES-1:0]          mem_ce_n,
  output logic                      mem_we_n,
  output logic                      mem_oe_n,
  output logic [LANES*LANE_W-1:0]   mem_dq_out,
  output logic                      mem_dq_oe,
  input  logic [LANES*LANE_W-1:0]   mem_dq_in
);

  localparam int DATA_W = LANES * LANE_W;
  localparam int RD_CYC = imax(ns_to_cycles(T_AA_NS, CLK_NS), ns_to_cycles(T_RC_NS, CLK_NS));
  localparam int HZ_CYC = ns_to_cycles(T_HZ_NS, CLK_NS);
  localparam int AS_CYC = ns_to_cycles(T_AS_NS, CLK_NS);
  localparam int WP_CYC = imax(ns_to_cycles(T_WP_NS, CLK_NS),
                               imax(ns_to_cycles(T_AW_NS, CLK_NS), ns_to_cycles(T_DW_NS, CLK_NS)));
  localparam int WC_CYC = ns_to_cycles(T_WC_NS, CLK_NS);
  localparam int DH_CYC = imax(ns_to_cycles(T_DH_NS, CLK_NS), WC_CYC - AS_CYC - WP_CYC);
  localparam int MAX_CYC = imax(imax(RD_CYC, HZ_CYC), imax(imax(AS_CYC, WP_CYC), DH_CYC));
  localparam int CNT_W  = $clog2(MAX_CYC + 1);

  phase_e              ph_q, ph_d;
  logic [ADDR_W-1:0]   a_addr_q;
  logic [LANES-1:0]    a_lanes_q;
  logic [DATA_W-1:0]   a_wdata_q;
  logic                t_load, t_done;
  logic [CNT_W-1:0]    t_val;
  logic                lanes_active;
  logic [DATA_W-1:0]   rd_masked;

  // phase sequencing
  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE:     if (req_valid) ph_d = req_write ? PH_WR_SETUP : PH_RD_ACC;
      PH_RD_ACC:   if (t_done) ph_d = PH_RD_TURN;
      PH_RD_TURN:  if (t_done) ph_d = PH_IDLE;
      PH_WR_SETUP: if (t_done) ph_d = PH_WR_PULSE;
      PH_WR_PULSE: if (t_done) ph_d = PH_WR_HOLD;
      PH_WR_HOLD:  if (t_done) ph_d = PH_IDLE;
      default:     ph_d = PH_IDLE;
    endcase
  end

  // length of the phase being entered
  always_comb begin
    t_load = (ph_d != ph_q);
    unique case (ph_d)
      PH_RD_ACC:   t_val = CNT_W'(RD_CYC - 1);
      PH_RD_TURN:  t_val = CNT_W'(HZ_CYC - 1);
      PH_WR_SETUP: t_val = CNT_W'(AS_CYC - 1);
      PH_WR_PULSE: t_val = CNT_W'(WP_CYC - 1);
      PH_WR_HOLD:  t_val = CNT_W'(DH_CYC - 1);
      default:     t_val = '0;
    endcase
  end

  sram_phase_timer #(.CNT_W(CNT_W)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .done     (t_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q      <= PH_IDLE;
      a_addr_q  <= '0;
      a_lanes_q <= '0;
      a_wdata_q <= '0;
    end else begin
      ph_q <= ph_d;
      if (ph_q == PH_IDLE && req_valid) begin
        a_addr_q  <= req_addr;
        a_lanes_q <= req_lanes;
        a_wdata_q <= req_wdata;
      end
    end
  end

  assign lanes_active = (ph_q == PH_RD_ACC)   || (ph_q == PH_WR_SETUP) ||
                        (ph_q == PH_WR_PULSE) || (ph_q == PH_WR_HOLD);

  sram_lane_map #(.LANES(LANES), .LANE_W(LANE_W), .DATA_W(DATA_W)) i_lanes (
    .active    (lanes_active),
    .mask      (a_lanes_q),
    .dq_in     (mem_dq_in),
    .ce_n      (mem_ce_n),
    .rd_masked (rd_masked)
  );

  // read return
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= (ph_q == PH_RD_ACC) && t_done;
      if ((ph_q == PH_RD_ACC) && t_done) rsp_rdata <= rd_masked;
    end
  end

  assign req_ready  = (ph_q == PH_IDLE);
  assign mem_addr   = a_addr_q;
  assign mem_oe_n   = (ph_q != PH_RD_ACC);
  assign mem_we_n   = (ph_q != PH_WR_PULSE);
  assign mem_dq_oe  = (ph_q == PH_WR_PULSE) || (ph_q == PH_WR_HOLD);
  assign mem_dq_out = a_wdata_q;

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int LANES   = 4,
  parameter int CLK_NS  = 10,
  parameter int T_WP_NS = 12,
  parameter int T_HZ_NS = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [LANES-1:0]  mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);

  localparam int WP_MIN = ns_to_cycles(T_WP_NS, CLK_NS);
  localparam int HZ_MIN = ns_to_cycles(T_HZ_NS, CLK_NS);

  logic [7:0] we_low_cnt;
  logic [7:0] oe_high_cnt;
  logic       any_ce;

  assign any_ce = (mem_ce_n != '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_low_cnt  <= '0;
      oe_high_cnt <= 8'hFF;
    end else begin
      if (!mem_we_n) we_low_cnt <= (we_low_cnt == 8'hFF) ? we_low_cnt : we_low_cnt + 1'b1;
      else           we_low_cnt <= '0;
      if (!mem_oe_n) oe_high_cnt <= '0;
      else           oe_high_cnt <= (oe_high_cnt == 8'hFF) ? oe_high_cnt : oe_high_cnt + 1'b1;
    end
  end

  AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R2

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R5

  AST_WE_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_cnt >= 8'(WP_MIN))); // R6

  AST_WE_NOT_WITH_OE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n); // R6

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n); // R8

  AST_TURNAROUND_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (oe_high_cnt >= 8'(HZ_MIN))); // R9

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (any_ce && $past(any_ce)) |-> ($stable(mem_addr) && $stable(mem_ce_n))); // R10

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
  .ADDR_W  (ADDR_W),
  .LANES   (LANES),
  .CLK_NS  (CLK_NS),
  .T_WP_NS (T_WP_NS),
  .T_HZ_NS (T_HZ_NS)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/test_sram_lane_ctrl.sv
module test_sram_lane_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 20;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int DATA_W = LANES * LANE_W;
  // expected phase lengths from the requirements at 10 ns
  localparam int EXP_RD = 2;
  localparam int EXP_WP = 2;
  localparam int EXP_AS = 1;
  localparam int EXP_HZ = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LANES-1:0]  req_lanes = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DATA_W-1:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic [ADDR_W-1:0] mem_addr;
  logic [LANES-1:0]  mem_ce_n;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_lane_ctrl i_sram_lane_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_lanes(req_lanes), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DATA_W-1:0] init_word(input logic [ADDR_W-1:0] a);
    return {a[17:0] ^ 18'h2B5C3, ~a[17:0]};
  endfunction

  function automatic logic [DATA_W-1:0] lane_bits(input logic [LANES-1:0] m);
    logic [DATA_W-1:0] r;
    for (int k = 0; k < LANES; k++) r[k*LANE_W +: LANE_W] = {LANE_W{m[k]}};
    return r;
  endfunction

  // external memory model
  logic [DATA_W-1:0] ram [int unsigned];
  logic [DATA_W-1:0] shadow [int unsigned];

  always @(posedge clk) begin
    if (rst_n && mem_we_n === 1'b0 && mem_dq_oe === 1'b1) begin
      logic [DATA_W-1:0] w;
      w = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : init_word(mem_addr);
      for (int k = 0; k < LANES; k++)
        if (mem_ce_n[k] === 1'b0) w[k*LANE_W +: LANE_W] = mem_dq_out[k*LANE_W +: LANE_W];
      ram[int'(mem_addr)] = w;
    end
  end

  always @(*) begin
    logic [DATA_W-1:0] w;
    w = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : init_word(mem_addr);
    for (int k = 0; k < LANES; k++)
      mem_dq_in[k*LANE_W +: LANE_W] = (mem_ce_n[k] === 1'b0 && mem_oe_n === 1'b0 && mem_we_n === 1'b1)
                                      ? w[k*LANE_W +: LANE_W] : 9'h1A5;
  end

  // scoreboard
  logic [DATA_W-1:0] exp_q [$];

  task automatic issue(input bit wr, input logic [ADDR_W-1:0] a, input logic [LANES-1:0] m,
                       input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] cur;
    cur = shadow.exists(int'(a)) ? shadow[int'(a)] : init_word(a);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_lanes = m; req_wdata = d;
    while (!req_ready) @(negedge clk);
    if (wr) shadow[int'(a)] = (cur & ~lane_bits(m)) | (d & lane_bits(m));
    else    exp_q.push_back(cur & lane_bits(m));
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R2 ready low after accept", 64'(req_ready), 64'd0);
    chk(mem_ce_n == ~m, "R3 lane enables", 64'(mem_ce_n), 64'(~m));
    chk(mem_addr == a, "R10 address presented", 64'(mem_addr), 64'(a));
  endtask

  // monitor
  int oe_cnt = 0, we_cnt = 0, setup_cnt = 0, gap_cnt = 100;
  logic prev_we = 1'b1, prev_oe_dq = 1'b0, in_acc = 1'b0, acc_bad = 1'b0;
  logic [ADDR_W-1:0] acc_addr;
  logic [LANES-1:0]  acc_ce;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R5 unexpected response", 64'(rsp_rdata), 64'd0);
        else begin
          logic [DATA_W-1:0] e;
          e = exp_q.pop_front();
          chk(rsp_rdata == e, "R5 R7 read data", 64'(rsp_rdata), 64'(e));
        end
      end
      if (!mem_oe_n) oe_cnt++;
      else if (oe_cnt > 0) begin
        chk(oe_cnt == EXP_RD, "R4 read phase length", 64'(oe_cnt), 64'(EXP_RD));
        oe_cnt = 0;
      end
      if (prev_we && !mem_we_n)
        chk(setup_cnt == EXP_AS, "R6 write setup", 64'(setup_cnt), 64'(EXP_AS));
      if (!req_ready && mem_oe_n && mem_we_n && !mem_dq_oe) setup_cnt++;
      else setup_cnt = 0;
      if (!mem_we_n) we_cnt++;
      else if (we_cnt > 0) begin
        chk(we_cnt == EXP_WP, "R6 strobe length", 64'(we_cnt), 64'(EXP_WP));
        chk(mem_dq_oe == 1'b1, "R6 data held after strobe", 64'(mem_dq_oe), 64'd1);
        we_cnt = 0;
      end
      if (mem_dq_oe && !prev_oe_dq) begin
        chk(mem_oe_n == 1'b1, "R8 drive with outputs off", 64'(mem_oe_n), 64'd1);
        chk(gap_cnt >= EXP_HZ, "R9 release gap", 64'(gap_cnt), 64'(EXP_HZ));
      end
      if (mem_dq_oe && !mem_oe_n) chk(1'b0, "R8 bus contention", 64'(mem_oe_n), 64'd1);
      if (!mem_oe_n) gap_cnt = 0; else if (gap_cnt < 100) gap_cnt++;
      if (mem_ce_n != '1) begin
        if (!in_acc) begin acc_addr = mem_addr; acc_ce = mem_ce_n; acc_bad = 1'b0; end
        else if (mem_addr != acc_addr || mem_ce_n != acc_ce) acc_bad = 1'b1;
        in_acc = 1'b1;
      end else if (in_acc) begin
        chk(!acc_bad, "R10 stable during access", 64'(acc_bad), 64'd0);
        in_acc = 1'b0;
      end
      prev_we = mem_we_n;
      prev_oe_dq = mem_dq_oe;
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    chk(1'b0, "R2 watchdog expired", 64'd0, 64'd1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    logic [31:0] rng;
    rng = 32'h1F2E3D4C;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(req_ready == 1'b1, "R1 ready", 64'(req_ready), 64'd1);
    chk(mem_ce_n == 4'hF, "R1 enables", 64'(mem_ce_n), 64'hF);
    chk(mem_we_n && mem_oe_n, "R1 strobes", 64'({mem_we_n, mem_oe_n}), 64'h3);
    chk(!mem_dq_oe && !rsp_valid, "R1 bus and response", 64'({mem_dq_oe, rsp_valid}), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && mem_ce_n == 4'hF, "R1 after reset", 64'({req_ready, mem_ce_n}), 64'h1F);

    issue(1'b0, 20'h00010, 4'hF, '0);                    // R4 unwritten word
    issue(1'b1, 20'h00010, 4'hF, 36'hA_BCDE_F012);
    issue(1'b0, 20'h00010, 4'hF, '0);
    issue(1'b1, 20'h00010, 4'b0101, 36'h5_5555_5555);    // R7 partial write
    issue(1'b0, 20'h00010, 4'hF, '0);
    issue(1'b0, 20'h00010, 4'b1010, '0);                 // R5 zero fill
    issue(1'b1, 20'hFFFFF, 4'b1000, 36'hF_0000_0000);    // R3 top lane, top address
    issue(1'b0, 20'hFFFFF, 4'hF, '0);
    issue(1'b0, 20'h00000, 4'b0000, '0);                 // R5 empty mask reads zero
    issue(1'b0, 20'h00020, 4'b0010, '0);                 // R9 read then write
    issue(1'b1, 20'h00020, 4'b0010, 36'h0_0003_FE00);
    issue(1'b0, 20'h00020, 4'hF, '0);
    for (int i = 0; i < 60; i++) begin
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      issue(rng[0], {16'h0, rng[4:1]}, rng[8:5], {rng[31:9], rng[12:0]});
    end
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all responses returned", 64'(exp_q.size()), 64'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule